// File: doc/BRIEF.md
# Indirect Peripheral Clock Control Register

This block holds the clock enable and power-of-two divider of every peripheral on a chip behind a single control word. Software first writes the word with the command bit clear to point the block at one peripheral ID, then reads the same word to see that peripheral's divider and enable. A write with the command bit set changes the divider and enable of the named peripheral in one step.

Each peripheral gets a clock-enable strobe. A shared 3-bit free-running counter paces all strobes, so an enabled peripheral with divider n strobes in every cycle where the low n counter bits are zero. That is once every 2^n input cycles. The lowest IDs are reserved. They always strobe every cycle and ignore commands.

Top module: `pclk_ctrl_reg`

## Requirements
- R1: After reset, every controllable peripheral is disabled with divider 0 and drives no strobe, and the latched ID is 0.
- R2: Control word layout: ID in bits 5:0, command in bit 12, divider in bits 17:16, enable in bit 28. On a read, the command bit and every unlisted bit return 0.
- R3: A write with bit 12 clear latches the ID for readback and changes no peripheral's enable or divider, whatever the other bits hold.
- R4: A write with bit 12 set stores bits 17:16 and bit 28 into the named controllable peripheral and also latches its ID. The readback reflects the new state in the next cycle.
- R5: A command write with bit 28 clear disables the peripheral, so it drives no strobe.
- R6: IDs 0 and 1 strobe every cycle and read back enable 1 and divider 0. Command writes to them have no effect.
- R7: An enabled peripheral with divider n strobes exactly 8/2^n times in any 8 consecutive cycles, one strobe every 2^n cycles.
- R8: Strobes come from one shared counter. Whenever a peripheral with divider n strobes, every enabled peripheral with a divider below n strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 32 | Control word written |
| rdata_o | output | 32 | State of the latched peripheral |
| strobe_o | output | 64 | Per-peripheral clock-enable strobes |

## Verification
The bench builds the block with its default 64 peripherals and 2 reserved IDs. This covers the full 6-bit ID field, including the highest ID 63 and the boundary between ID 1 and ID 2. With all four divider values and both enable states in use at once, the shared-counter alignment between divisors is observable in every 8-cycle window. Random select and command writes mixed across the whole ID range reach the readback path for every kind of ID.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int WORD_W  = 32;
  localparam int ID_W    = 6;
  localparam int DIV_W   = 2;
  localparam int CNT_W   = (1 << DIV_W) - 1;
  localparam int ID_LSB  = 0;
  localparam int CMD_BIT = 12;
  localparam int DIV_LSB = 16;
  localparam int EN_BIT  = 28;

  typedef struct packed {
    logic             cmd;
    logic [ID_W-1:0]  id;
    logic [DIV_W-1:0] div;
    logic             en;
  } pclk_req_t;
endpackage

// File: rtl/pclk_word_codec.sv
module pclk_word_codec
  import pclk_pkg::*;
(
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ID_W-1:0]   sel_id_i,
  input  logic [DIV_W-1:0]  sel_div_i,
  input  logic              sel_en_i,
  output pclk_req_t         req_o,
  output logic [WORD_W-1:0] rdata_o
);
  always_comb begin
    req_o.cmd = wdata_i[CMD_BIT];
    req_o.id  = wdata_i[ID_LSB +: ID_W];
    req_o.div = wdata_i[DIV_LSB +: DIV_W];
    req_o.en  = wdata_i[EN_BIT];
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[ID_LSB +: ID_W]      = sel_id_i;
    rdata_o[DIV_LSB +: DIV_W]    = sel_div_i;
    rdata_o[EN_BIT]              = sel_en_i;
  end
endmodule

// File: rtl/pclk_state_bank.sv
module pclk_state_bank
  import pclk_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int NUM_FIXED  = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  pclk_req_t                        req_i,
  output logic [ID_W-1:0]                  sel_id_o,
  output logic                             sel_en_o,
  output logic [DIV_W-1:0]                 sel_div_o,
  output logic [NUM_PERIPH-1:0]            en_o,
  output logic [NUM_PERIPH-1:0][DIV_W-1:0] div_o
);
  localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  logic [ID_W-1:0] sel_id_q;
  logic            cmd_wr;
  logic            sel_valid;

  assign cmd_wr = we_i && req_i.cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_id_q <= '0;
    else if (we_i) sel_id_q <= req_i.id;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
    if (i < NUM_FIXED) begin : g_fixed
      assign en_o[i]  = 1'b1;
      assign div_o[i] = '0;
    end else begin : g_ctrl
      logic             en_q;
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q  <= 1'b0;
          div_q <= '0;
        end else if (cmd_wr && req_i.id == ID_W'(i)) begin
          en_q  <= req_i.en;
          div_q <= req_i.div;
        end
      end
      assign en_o[i]  = en_q;
      assign div_o[i] = div_q;
    end
  end

  assign sel_valid = 32'(sel_id_q) < NUM_PERIPH;
  assign sel_id_o  = sel_id_q;
  assign sel_en_o  = sel_valid ? en_o[sel_id_q[IDX_W-1:0]] : 1'b0;
  assign sel_div_o = sel_valid ? div_o[sel_id_q[IDX_W-1:0]] : '0;

  assert_sel_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sel_id_q == $past(req_i.id));

  assert_select_no_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !req_i.cmd) |=> ($stable(en_o) && $stable(div_o)));

  assert_cmd_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && 32'(req_i.id) >= NUM_FIXED && 32'(req_i.id) < NUM_PERIPH)
    |=> (sel_en_o == $past(req_i.en) && sel_div_o == $past(req_i.div)));
endmodule

// File: rtl/pclk_strobe_gen.sv
module pclk_strobe_gen
  import pclk_pkg::*;
#(
  parameter int NUM_PERIPH = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PERIPH-1:0]            en_i,
  input  logic [NUM_PERIPH-1:0][DIV_W-1:0] div_i,
  output logic [NUM_PERIPH-1:0]            strobe_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_strobe
    logic [CNT_W-1:0] mask;
    assign mask        = CNT_W'((1 << div_i[i]) - 1);
    assign strobe_o[i] = en_i[i] && ((cnt_q & mask) == '0);
  end

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/pclk_ctrl_reg.sv
module pclk_ctrl_reg
  import pclk_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int NUM_FIXED  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic [NUM_PERIPH-1:0] strobe_o
);
  pclk_req_t                        req;
  logic [ID_W-1:0]                  sel_id;
  logic                             sel_en;
  logic [DIV_W-1:0]                 sel_div;
  logic [NUM_PERIPH-1:0]            en_vec;
  logic [NUM_PERIPH-1:0][DIV_W-1:0] div_vec;

  pclk_word_codec u_codec (
    .wdata_i  (wdata_i),
    .sel_id_i (sel_id),
    .sel_div_i(sel_div),
    .sel_en_i (sel_en),
    .req_o    (req),
    .rdata_o  (rdata_o)
  );

  pclk_state_bank #(.NUM_PERIPH(NUM_PERIPH), .NUM_FIXED(NUM_FIXED)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .req_i    (req),
    .sel_id_o (sel_id),
    .sel_en_o (sel_en),
    .sel_div_o(sel_div),
    .en_o     (en_vec),
    .div_o    (div_vec)
  );

  pclk_strobe_gen #(.NUM_PERIPH(NUM_PERIPH)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_vec),
    .div_i   (div_vec),
    .strobe_o(strobe_o)
  );

  assert_fixed_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &strobe_o[NUM_FIXED-1:0]);

  assert_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && req.cmd && !req.en && 32'(req.id) >= NUM_FIXED && 32'(req.id) < NUM_PERIPH)
    |=> !(|(strobe_o & (NUM_PERIPH'(1) << $past(req.id)))));
endmodule

// File: tb/tb_pclk_ctrl_reg.sv
`timescale 1ns/1ps
module tb_pclk_ctrl_reg;
  localparam int NP = 64;
  localparam int NF = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] strobe_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 1'b0;

  bit       m_en [NP];
  bit [1:0] m_div[NP];
  bit [5:0] m_sel;

  always #2.5 clk = ~clk;

  pclk_ctrl_reg #(.NUM_PERIPH(NP), .NUM_FIXED(NF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .strobe_o(strobe_o)
  );

  function automatic logic [31:0] make_word(bit cmd, bit [5:0] id, bit [1:0] dv, bit en);
    logic [31:0] w;
    w = '0;
    w[5:0] = id; w[12] = cmd; w[17:16] = dv; w[28] = en;
    return w;
  endfunction

  function automatic logic [31:0] exp_read();
    return make_word(1'b0, m_sel, m_div[m_sel], m_en[m_sel]);
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [31:0] w);
    @(negedge clk);
    we_i = 1'b1; wdata_i = w;
    @(negedge clk);
    we_i = 1'b0; wdata_i = '0;
    m_sel = w[5:0];
    if (w[12] && w[5:0] >= NF) begin
      m_en[w[5:0]]  = w[28];
      m_div[w[5:0]] = w[17:16];
    end
  endtask

  // R7: per-window strobe count; R8: shared-counter alignment; R5/R6 via counts
  task automatic window_check(string tag);
    int cnt[NP];
    bit align_ok = 1'b1;
    for (int i = 0; i < NP; i++) cnt[i] = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
        if (strobe_o[i]) begin
          cnt[i]++;
          for (int j = 0; j < NP; j++)
            if (m_en[j] && m_div[j] < m_div[i] && !strobe_o[j]) align_ok = 1'b0;
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      int exp;
      exp = m_en[i] ? (8 >> m_div[i]) : 0;
      checks++;
      if (cnt[i] != exp) begin
        errors++;
        $display("FAIL R7 %s id=%0d strobes actual=%0d expected=%0d", tag, i, cnt[i], exp);
      end
    end
    checks++;
    if (!align_ok) begin
      errors++;
      $display("FAIL R8 %s alignment actual=0 expected=1", tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1357);
    for (int i = 0; i < NP; i++) begin
      m_en[i]  = (i < NF);
      m_div[i] = 2'd0;
    end
    m_sel = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    check32("R1 readback", rdata_o, 32'h1000_0000);
    check32("R1 strobes", 32'(strobe_o[31:0]), 32'h3);
    check32("R1 strobes hi", 32'(strobe_o[63:32]), 32'h0);

    // R2/R3: select with stray bits, including enable set and command clear
    reg_write(32'hFFFF_EFC5);
    check32("R2 R3 select stray bits", rdata_o, 32'h1000_0000 & 32'h0 | 32'h5);
    window_check("R3 after select");

    // R4: highest ID, divider 3
    reg_write(make_word(1'b1, 6'd63, 2'd3, 1'b1));
    check32("R4 id63", rdata_o, 32'h1003_003F);
    // R4: ID 2 at fixed boundary, divider 0
    reg_write(make_word(1'b1, 6'd2, 2'd0, 1'b1));
    check32("R4 id2", rdata_o, 32'h1000_0002);
    reg_write(make_word(1'b1, 6'd10, 2'd1, 1'b1));
    reg_write(make_word(1'b1, 6'd11, 2'd2, 1'b1));
    check32("R4 id11", rdata_o, exp_read());
    window_check("R7 mixed dividers");

    // R6: command to reserved ID ignored
    reg_write(make_word(1'b1, 6'd1, 2'd2, 1'b0));
    check32("R6 id1 readback", rdata_o, 32'h1000_0001);
    reg_write(make_word(1'b1, 6'd0, 2'd3, 1'b0));
    check32("R6 id0 readback", rdata_o, 32'h1000_0000);
    window_check("R6 reserved");

    // R5: disable
    reg_write(make_word(1'b1, 6'd63, 2'd3, 1'b0));
    check32("R5 id63 off", rdata_o, 32'h0003_003F);
    window_check("R5 disabled");

    // Random mix
    for (int it = 0; it < 60; it++) begin
      bit [5:0] id;
      logic [31:0] w;
      id = 6'($urandom);
      w  = $urandom;
      w[5:0] = id;
      w[12] = ($urandom % 3) != 0;
      reg_write(w);
      if (w[12]) check32("R4 random cmd", rdata_o, exp_read());
      else       check32("R3 random select", rdata_o, exp_read());
      if (it % 6 == 5) window_check("R7 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule